// File: doc/BRIEF.md
# Digital Back Porch Clamp

The block re-references a digitized composite video stream so that its blanking level sits on a fixed code chosen by the video standard. Samples arrive at half the clock rate, flagged by a valid enable. An external line-timing strobe marks the back porch interval. Inside that interval the block runs the samples through a short moving-average filter to remove colour subcarrier and noise, and averages a fixed number of the filtered values into a measured blanking level.

Every sample is then shifted by the difference between the target code and the measured level. The target is 3Ch for the 525-line standard and 40h for the 625-line standard. Results clip at the ends of the 8-bit range. The shift can be switched off, in which case samples leave the block unchanged. A flag shows once a first level has been measured. Until then the block uses the target code as the level, so the output equals the input.

Top module: `porch_clamp`

## Requirements
- R1: With clampEn=1 and palMode=0 (target 3Ch), the clock edge at which sampleEn=1 loads sampleOut with sampleIn minus the effective level plus 3Ch. The effective level is the measured level when levelValid=1 and the target code otherwise.
- R2: With clampEn=1 and palMode=1, the same rule applies with target code 40h.
- R3: With clampEn=0, the clock edge at which sampleEn=1 loads sampleOut with sampleIn unchanged.
- R4: The filtered value is floor((x0+x1+x2+x3)/4). Here x0 is the current sample and x1..x3 are the three previous accepted samples, which are zero after reset. The history advances on every sampleEn, inside or outside the window. The measured level is floor(sum/32) of the filtered values.
- R5: Only the first 32 samples with sampleEn=1 while porchWin=1 are accumulated. The level is committed on the first clock with porchWin=0 after a window. The commit happens only if 32 samples were collected. A shorter window leaves level and levelValid unchanged.
- R6: The measured level holds between commits. A sample accepted in the commit cycle itself is adjusted with the previous level.
- R7: The adjusted result saturates to 00h below zero and to FFh above 255; it never wraps.
- R8: levelValid is 0 after reset, becomes 1 at the first commit and then stays 1. Before that, output equals input in either standard.
- R9: sampleOut changes only at clock edges where sampleEn=1.
- R10: During reset (rstN=0), sampleOut is 00h and levelValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Sample valid enable |
| sampleIn | input | 8 | Digitized composite sample |
| porchWin | input | 1 | High during the back porch interval |
| palMode | input | 1 | 1 selects target 40h, 0 selects 3Ch |
| clampEn | input | 1 | 1 enables the level shift |
| sampleOut | output | 8 | Clamped (or passed) sample |
| levelValid | output | 1 | A measured level is in use |

## Verification
Two functions can fall in the same cycle: the level commit at the end of a window, and the adjustment of a sample. The bench provokes this by closing a full window with sampleEn high in the closing cycle. It expects that sample to carry the previous level and the next sample to carry the new one. A bench model computes the filter, the 32-sample average and the saturated result arithmetically. Against this model the bench sweeps all 256 input codes in both standards, before and after measurement, with the clamp on and off.

// File: rtl/porch_clamp_pkg.sv
package porch_clamp_pkg;

  // Strobes sent from the window control to the datapath
  typedef struct packed {
    logic accFirst;  // load accumulator with the first filtered value
    logic accStep;   // add a filtered value to the accumulator
    logic commit;    // move the averaged sum into the level register
  } clampStrobes_t;

endpackage

// File: rtl/porch_clamp_ctrl.sv
module porch_clamp_ctrl
  import porch_clamp_pkg::*;
#(
  parameter int unsigned ACC_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleEn,
  input  logic          porchWin,
  output clampStrobes_t strobes
);

  localparam int unsigned CNT_W   = ACC_LOG2 + 1;
  localparam int unsigned ACC_LEN = 1 << ACC_LOG2;

  logic [CNT_W-1:0] fillCnt;
  logic             winPrev;
  logic             isFull;

  assign isFull = (fillCnt == CNT_W'(ACC_LEN));

  always_comb begin
    strobes          = '0;
    strobes.accStep  = sampleEn && porchWin && !isFull;
    strobes.accFirst = strobes.accStep && (fillCnt == '0);
    strobes.commit   = !porchWin && winPrev && isFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      winPrev <= 1'b0;
    end else begin
      winPrev <= porchWin;
      if (!porchWin) begin
        fillCnt <= '0;
      end else if (strobes.accStep) begin
        fillCnt <= fillCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/porch_clamp_dp.sv
module porch_clamp_dp
  import porch_clamp_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TAPS_LOG2 = 2,
  parameter int unsigned ACC_LOG2  = 5,
  parameter logic [DATA_W-1:0] NTSC_CODE = 8'h3C,
  parameter logic [DATA_W-1:0] PAL_CODE  = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              palMode,
  input  logic              clampEn,
  input  clampStrobes_t     strobes,
  output logic [DATA_W-1:0] sampleOut,
  output logic              levelValid
);

  localparam int unsigned TAPS  = 1 << TAPS_LOG2;
  localparam int unsigned HIST  = TAPS - 1;
  localparam int unsigned SUM_W = DATA_W + TAPS_LOG2;
  localparam int unsigned ACC_W = DATA_W + ACC_LOG2;
  localparam int unsigned ADJ_W = DATA_W + 2;

  logic [DATA_W-1:0] hist [HIST];
  logic [SUM_W-1:0]  tapSum;
  logic [DATA_W-1:0] filtVal;
  logic [ACC_W-1:0]  acc;
  logic [DATA_W-1:0] levelReg;
  logic [DATA_W-1:0] target;
  logic [DATA_W-1:0] effLevel;
  logic signed [ADJ_W-1:0] diff;
  logic [DATA_W-1:0] adjVal;

  // Filter history: shifts on every accepted sample
  for (genvar g = 0; g < HIST; g++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hist[g] <= '0;
      end else if (sampleEn) begin
        if (g == 0) hist[g] <= sampleIn;
        else        hist[g] <= hist[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_comb begin
    tapSum = SUM_W'(sampleIn);
    for (int i = 0; i < HIST; i++) begin
      tapSum = tapSum + SUM_W'(hist[i]);
    end
  end

  assign filtVal = DATA_W'(tapSum >> TAPS_LOG2);

  // Level accumulation and commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      levelReg   <= '0;
      levelValid <= 1'b0;
    end else begin
      if (strobes.accFirst)     acc <= ACC_W'(filtVal);
      else if (strobes.accStep) acc <= acc + ACC_W'(filtVal);
      if (strobes.commit) begin
        levelReg   <= DATA_W'(acc >> ACC_LOG2);
        levelValid <= 1'b1;
      end
    end
  end

  // Re-reference and saturate
  assign target   = palMode ? PAL_CODE : NTSC_CODE;
  assign effLevel = levelValid ? levelReg : target;

  always_comb begin
    diff = $signed({2'b00, sampleIn}) - $signed({2'b00, effLevel})
         + $signed({2'b00, target});
    if (diff[ADJ_W-1])       adjVal = '0;
    else if (diff[DATA_W])   adjVal = '1;
    else                     adjVal = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (sampleEn) begin
      sampleOut <= clampEn ? adjVal : sampleIn;
    end
  end

endmodule

// File: rtl/porch_clamp.sv
module porch_clamp
  import porch_clamp_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TAPS_LOG2 = 2,
  parameter int unsigned ACC_LOG2  = 5,
  parameter logic [DATA_W-1:0] NTSC_CODE = 8'h3C,
  parameter logic [DATA_W-1:0] PAL_CODE  = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              porchWin,
  input  logic              palMode,
  input  logic              clampEn,
  output logic [DATA_W-1:0] sampleOut,
  output logic              levelValid
);

  clampStrobes_t strobes;

  porch_clamp_ctrl #(
    .ACC_LOG2 (ACC_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .porchWin (porchWin),
    .strobes  (strobes)
  );

  porch_clamp_dp #(
    .DATA_W    (DATA_W),
    .TAPS_LOG2 (TAPS_LOG2),
    .ACC_LOG2  (ACC_LOG2),
    .NTSC_CODE (NTSC_CODE),
    .PAL_CODE  (PAL_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleEn   (sampleEn),
    .sampleIn   (sampleIn),
    .palMode    (palMode),
    .clampEn    (clampEn),
    .strobes    (strobes),
    .sampleOut  (sampleOut),
    .levelValid (levelValid)
  );

endmodule

// File: rtl/porch_clamp_chk.sv
module porch_clamp_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleEn,
  input logic [DATA_W-1:0] sampleIn,
  input logic              porchWin,
  input logic              clampEn,
  input logic [DATA_W-1:0] sampleOut,
  input logic              levelValid
);

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && !clampEn) |=> (sampleOut == $past(sampleIn)));

  assert_identity_before_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && !levelValid) |=> (sampleOut == $past(sampleIn)));

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(levelValid));

  assert_hold_without_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(sampleOut));

  assert_commit_after_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(levelValid) |-> (!$past(porchWin) && $past(porchWin, 2)));

endmodule

bind porch_clamp porch_clamp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleEn   (sampleEn),
  .sampleIn   (sampleIn),
  .porchWin   (porchWin),
  .clampEn    (clampEn),
  .sampleOut  (sampleOut),
  .levelValid (levelValid)
);

// File: tb/porch_clamp_tb.sv
`timescale 1ns/1ps
module porch_clamp_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic [7:0] sampleIn = 8'h00;
  logic       porchWin = 1'b0;
  logic       palMode = 1'b0;
  logic       clampEn = 1'b0;
  logic [7:0] sampleOut;
  logic       levelValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int h0 = 0, h1 = 0, h2 = 0;
  int mCnt = 0, mAcc = 0, mLevel = 0;
  bit mValid = 1'b0, mPrevWin = 1'b0;
  int expOut = 0;

  always #2 clk = ~clk;  // 250 MHz

  porch_clamp u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .sampleEn   (sampleEn),
    .sampleIn   (sampleIn),
    .porchWin   (porchWin),
    .palMode    (palMode),
    .clampEn    (clampEn),
    .sampleOut  (sampleOut),
    .levelValid (levelValid)
  );

  function automatic int sat8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, update the model, check after the edge
  task automatic step(bit en, int x, bit win, string req);
    int tgt, eff, f;
    bit commit;
    sampleEn = en;
    sampleIn = 8'(x);
    porchWin = win;
    tgt = palMode ? 8'h40 : 8'h3C;
    eff = mValid ? mLevel : tgt;
    if (en) expOut = clampEn ? sat8(x - eff + tgt) : x;
    commit = !win && mPrevWin && (mCnt == 32);
    if (en && win && mCnt < 32) begin
      f = (x + h0 + h1 + h2) / 4;
      mAcc = (mCnt == 0) ? f : mAcc + f;
      mCnt++;
    end
    if (!win) mCnt = 0;
    if (en) begin
      h2 = h1; h1 = h0; h0 = x;
    end
    mPrevWin = win;
    @(posedge clk);
    #1;
    if (commit) begin
      mLevel = mAcc / 32;
      mValid = 1'b1;
    end
    check(req, int'(sampleOut), expOut);
    check(req, int'(levelValid), int'(mValid));
  endtask

  // One sample period: enable clock then idle clock with a different input
  task automatic pair(int x, bit win, string req);
    step(1'b1, x, win, req);
    step(1'b0, (x + 77) & 255, win, req);
  endtask

  task automatic window(int n, int base, int swing, string req);
    for (int i = 0; i < n; i++) begin
      pair(sat8(base + (((i & 1) != 0) ? swing : -swing)), 1'b1, req);
    end
  endtask

  task automatic sweep(string req);
    for (int v = 0; v < 256; v++) pair(v, 1'b0, req);
  endtask

  initial begin
    #10;
    // R10: reset state
    check("R10", int'(sampleOut), 0);
    check("R10", int'(levelValid), 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // R8: identity before any measurement, both standards
    clampEn = 1'b1;
    palMode = 1'b0;
    sweep("R8");
    palMode = 1'b1;
    sweep("R8");
    palMode = 1'b0;

    // R5: a short window must not commit a level
    window(20, 8'h50, 12, "R5");
    pair(8'h10, 1'b0, "R5");
    pair(8'h10, 1'b0, "R5");

    // R4 R5: full window with chroma-like swing, longer than 32 samples
    window(40, 8'h50, 10, "R4");
    step(1'b0, 8'h22, 1'b0, "R5");
    step(1'b1, 8'h22, 1'b0, "R5");

    // R1 R7: NTSC target, level above target so low codes clip to 00h
    sweep("R1");
    window(33, 8'h5A, 0, "R6");
    pair(8'h80, 1'b0, "R6");
    sweep("R7");

    // R3: clamp off passes samples through
    clampEn = 1'b0;
    sweep("R3");
    clampEn = 1'b1;

    // R6: commit collides with an accepted sample; old level applies there
    window(36, 8'h20, 6, "R6");
    step(1'b1, 8'h90, 1'b0, "R6");
    step(1'b0, 8'h91, 1'b0, "R6");
    pair(8'h90, 1'b0, "R6");

    // R2 R7: PAL target with a low level, high codes clip to FFh
    palMode = 1'b1;
    sweep("R2");
    sweep("R7");

    // R9: idle clocks with changing input keep the output
    for (int i = 0; i < 16; i++) step(1'b0, i * 13, 1'b0, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule